// File: doc/BRIEF.md
# Fractional-N Divide Value Sequencer

This block produces, once per phase-detector cycle, the whole-number division value for the feedback divider of a fractional-N synthesizer. Over time the values average to an integer part plus a fraction, numerator over a programmable modulus. The fractional part is produced by a chain of up to four modulo accumulators. Each accumulator adds its input to a stored residue, emits a carry when the sum reaches the modulus, and passes its new residue to the next stage. The carries are recombined through repeated first differences, so a higher order pushes quantization error towards high offsets. In exchange, the per-cycle offset spans a wider range.

The order (one to four) and the modulus are captured during synchronous reset and hold until the next reset. The numerator, the integer part and the dither enable act at once. With dither enabled, a 16-bit pseudo-random bit is added to the first stage's input each cycle. This breaks up the short repeating patterns that small fractions produce.

Top module: `frac_div_modulator`

## Requirements
- R1: Without dither, over L cycles after reset the summed offsets differ from L*num/den by no more than 8 in every order.
- R2: In order one (`ord_i` = 0) every offset is 0 or +1. With integer 900 and fraction 1/5 the outputs after reset are 900, 900, 900, 900, 901, repeating.
- R3: In order two (`ord_i` = 1) every offset lies within -1..+2.
- R4: In order three (`ord_i` = 2) every offset lies within -7..+8. In order four (`ord_i` = 3) every offset lies within -15..+16.
- R5: Each cycle, stage k computes s = residue_k + in_k. Its carry is 1 when s >= den, and its new residue is s minus den times the carry. The first stage's input is num plus the dither bit. Stage k>1 takes stage k-1's new residue. The offset is the sum, over stages 1..order, of stage k's carry differenced k-1 times against its own earlier carries, with carries taken as 0 before reset. `div_o` shows integer plus offset one clock after the edge that computes it.
- R6: With `dith_en_i` high, the dither bit is bit 0 of a 16-bit shift register. The register is seeded with 0xACE1 at reset. On every clock after reset it shifts left, taking as its new bit 0 the XOR of bits 15, 13, 12 and 10. It advances whether or not dither is enabled.
- R7: The dither register never holds all zeros.
- R8: With numerator zero and dither off, `div_o` equals `int_i` in every cycle, in every order.
- R9: While `srst_i` is high, every accumulator and carry history clears and `div_o` becomes `int_i` one clock later. `ord_i` and `den_i` are sampled only during reset, and changing them at other times has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase-detector clock |
| srst_i | input | 1 | Synchronous reset, active high; also samples order and modulus |
| int_i | input | INT_W | Integer part of the division value, at least 15 |
| num_i | input | MOD_W | Fraction numerator, below the modulus |
| den_i | input | MOD_W | Fractional modulus, at least 2 |
| ord_i | input | 2 | Modulator order minus one |
| dith_en_i | input | 1 | Adds the pseudo-random bit to the first stage |
| div_o | output | INT_W+1 | Division value for this cycle |

## Verification
The fraction 1/5 in order one pins down the exact carry cadence and the one-cycle output latency. Zero numerators in all four orders show that the higher stages stay quiet when the first stage has no residue. A fraction just below a full-scale modulus drives all four stages to their widest offsets and exercises the range bounds. Runs with dither enabled and disabled separate the shift-register sequence from the plain carry pattern. Randomly drawn moduli, numerators, orders and integers are compared cycle by cycle with a bench model that differences carry histories directly. Long runs bound the average error. Changing order and modulus between resets shows that the sampled configuration holds.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

  // Binomial coefficient C(n, k) for small n.
  function automatic int binom(input int n, input int k);
    int r;
    r = 1;
    for (int i = 0; i < k; i++) r = (r * (n - i)) / (i + 1);
    return r;
  endfunction

  // Weight of the carry j cycles back in a k-fold first difference.
  function automatic int tap_weight(input int k, input int j);
    return ((j % 2) == 1) ? -binom(k, j) : binom(k, j);
  endfunction

endpackage

// File: rtl/fracn_stage.sv
module fracn_stage #(
  parameter int MOD_W = 16
) (
  input  logic             clk_i,
  input  logic             srst_i,
  input  logic [MOD_W-1:0] den_i,
  input  logic [MOD_W:0]   add_i,
  output logic [MOD_W-1:0] res_o,
  output logic             cy_o
);
  logic [MOD_W-1:0] acc_q;
  logic [MOD_W+1:0] sum_c;

  always_comb begin
    sum_c = {2'b00, acc_q} + {1'b0, add_i};
    cy_o  = (sum_c >= {2'b00, den_i});
    res_o = cy_o ? MOD_W'(sum_c - {2'b00, den_i}) : MOD_W'(sum_c);
  end

  always_ff @(posedge clk_i) begin
    if (srst_i) acc_q <= '0;
    else        acc_q <= res_o;
  end
endmodule

// File: rtl/fracn_combine.sv
module fracn_combine
  import fracn_pkg::*;
#(
  parameter int NSTAGE = 4,
  parameter int ORD_W  = 2,
  parameter int OFS_W  = 6
) (
  input  logic                    clk_i,
  input  logic                    srst_i,
  input  logic [NSTAGE-1:0]       cy_i,
  input  logic [ORD_W-1:0]        ord_i,
  output logic signed [OFS_W-1:0] ofs_o
);
  logic signed [OFS_W-1:0] term [NSTAGE];

  for (genvar gk = 0; gk < NSTAGE; gk++) begin : g_term
    if (gk == 0) begin : g_first
      assign term[gk] = OFS_W'(int'(cy_i[gk]));
    end else begin : g_diff
      logic [gk-1:0] hist_q;
      int            t_c;

      always_ff @(posedge clk_i) begin
        if (srst_i) hist_q <= '0;
        else begin
          hist_q[0] <= cy_i[gk];
          for (int j = 1; j < gk; j++) hist_q[j] <= hist_q[j-1];
        end
      end

      always_comb begin
        t_c = tap_weight(gk, 0) * int'(cy_i[gk]);
        for (int j = 1; j <= gk; j++) t_c = t_c + tap_weight(gk, j) * int'(hist_q[j-1]);
      end
      assign term[gk] = OFS_W'(t_c);
    end
  end

  always_comb begin
    int s;
    s = 0;
    for (int k = 0; k < NSTAGE; k++) begin
      if (k <= int'(ord_i)) s = s + int'(term[k]);
    end
    ofs_o = OFS_W'(s);
  end
endmodule

// File: rtl/frac_div_modulator.sv
module frac_div_modulator #(
  parameter int                INT_W     = 12,
  parameter int                MOD_W     = 16,
  parameter int                NSTAGE    = 4,
  parameter int                LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int               ORD_W     = $clog2(NSTAGE),
  localparam int               DIV_W     = INT_W + 1,
  localparam int               OFS_W     = NSTAGE + 2
) (
  input  logic             clk_i,
  input  logic             srst_i,
  input  logic [INT_W-1:0] int_i,
  input  logic [MOD_W-1:0] num_i,
  input  logic [MOD_W-1:0] den_i,
  input  logic [ORD_W-1:0] ord_i,
  input  logic             dith_en_i,
  output logic [DIV_W-1:0] div_o
);
  logic [MOD_W-1:0]        den_q;
  logic [ORD_W-1:0]        ord_q;
  logic [LFSR_W-1:0]       lfsr_q;
  logic                    dith_bit;
  logic [MOD_W:0]          add   [NSTAGE];
  logic [MOD_W-1:0]        res   [NSTAGE];
  logic [NSTAGE-1:0]       cy;
  logic signed [OFS_W-1:0] ofs_c;
  logic signed [OFS_W-1:0] ofs_q;
  logic [DIV_W-1:0]        div_c;

  // Configuration is sampled only while reset is held.
  always_ff @(posedge clk_i) begin
    if (srst_i) begin
      den_q <= den_i;
      ord_q <= ord_i;
    end
  end

  // Dither source: left-shifting maximal-length register.
  always_ff @(posedge clk_i) begin
    if (srst_i) lfsr_q <= LFSR_SEED;
    else        lfsr_q <= {lfsr_q[LFSR_W-2:0], ^(lfsr_q & LFSR_TAPS)};
  end
  assign dith_bit = dith_en_i & lfsr_q[0];

  for (genvar gs = 0; gs < NSTAGE; gs++) begin : g_stage
    if (gs == 0) begin : g_in0
      assign add[gs] = {1'b0, num_i} + {{MOD_W{1'b0}}, dith_bit};
    end else begin : g_inn
      assign add[gs] = {1'b0, res[gs-1]};
    end
    fracn_stage #(.MOD_W(MOD_W)) u_stage (
      .clk_i  (clk_i),
      .srst_i (srst_i),
      .den_i  (den_q),
      .add_i  (add[gs]),
      .res_o  (res[gs]),
      .cy_o   (cy[gs])
    );
  end

  fracn_combine #(.NSTAGE(NSTAGE), .ORD_W(ORD_W), .OFS_W(OFS_W)) u_combine (
    .clk_i  (clk_i),
    .srst_i (srst_i),
    .cy_i   (cy),
    .ord_i  (ord_q),
    .ofs_o  (ofs_c)
  );

  assign div_c = DIV_W'($signed({1'b0, int_i}) + DIV_W'(ofs_c));

  always_ff @(posedge clk_i) begin
    if (srst_i) begin
      ofs_q <= '0;
      div_o <= DIV_W'(int_i);
    end else begin
      ofs_q <= ofs_c;
      div_o <= div_c;
    end
  end
endmodule

// File: rtl/frac_div_modulator_chk.sv
module frac_div_modulator_chk #(
  parameter int INT_W  = 12,
  parameter int ORD_W  = 2,
  parameter int OFS_W  = 6,
  parameter int LFSR_W = 16
) (
  input logic                    clk_i,
  input logic                    srst_i,
  input logic [INT_W-1:0]        int_i,
  input logic [INT_W:0]          div_o,
  input logic signed [OFS_W-1:0] ofs_q,
  input logic [ORD_W-1:0]        ord_q,
  input logic [LFSR_W-1:0]       lfsr_q
);
  // R2
  ord1_span_chk: assert property (@(posedge clk_i) disable iff (srst_i)
    (ord_q == 0) |-> (ofs_q == 0 || ofs_q == 1));
  // R3
  ord2_span_chk: assert property (@(posedge clk_i) disable iff (srst_i)
    (ord_q == 1) |-> (ofs_q >= -1 && ofs_q <= 2));
  // R4
  ord3_span_chk: assert property (@(posedge clk_i) disable iff (srst_i)
    (ord_q == 2) |-> (ofs_q >= -7 && ofs_q <= 8));
  // R4
  ord4_span_chk: assert property (@(posedge clk_i) disable iff (srst_i)
    (ord_q == 3) |-> (ofs_q >= -15 && ofs_q <= 16));
  // R7
  lfsr_live_chk: assert property (@(posedge clk_i) disable iff (srst_i)
    lfsr_q != '0);
  // R9
  reset_out_chk: assert property (@(posedge clk_i)
    srst_i |=> (div_o == {1'b0, $past(int_i)}));
endmodule

bind frac_div_modulator frac_div_modulator_chk #(
  .INT_W(INT_W), .ORD_W(ORD_W), .OFS_W(OFS_W), .LFSR_W(LFSR_W)
) u_chk (
  .clk_i  (clk_i),
  .srst_i (srst_i),
  .int_i  (int_i),
  .div_o  (div_o),
  .ofs_q  (ofs_q),
  .ord_q  (ord_q),
  .lfsr_q (lfsr_q)
);

// File: tb/frac_div_modulator_tb_top.sv
`timescale 1ns/1ps
module frac_div_modulator_tb_top;
  localparam int INT_W = 12;
  localparam int MOD_W = 16;

  logic             clk = 1'b0;
  logic             srst = 1'b1;
  logic [INT_W-1:0] int_v = '0;
  logic [MOD_W-1:0] num_v = '0;
  logic [MOD_W-1:0] den_v = 16'd5;
  logic [1:0]       ord_v = '0;
  logic             dith_v = 1'b0;
  logic [INT_W:0]   div;

  always #2 clk = ~clk;

  frac_div_modulator dut_i (
    .clk_i(clk), .srst_i(srst), .int_i(int_v), .num_i(num_v), .den_i(den_v),
    .ord_i(ord_v), .dith_en_i(dith_v), .div_o(div)
  );

  int errs = 0;
  int checks = 0;

  // Bench model state
  int          m_acc [4];
  int          m_hist[4][4];
  logic [15:0] m_lf;
  int          m_ord;
  int          m_den;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  function automatic int lo_bound(input int o);
    case (o) 1: return 0; 2: return -1; 3: return -7; default: return -15; endcase
  endfunction
  function automatic int hi_bound(input int o);
    case (o) 1: return 1; 2: return 2; 3: return 8; default: return 16; endcase
  endfunction

  function automatic int model_step(input int num, input bit dith);
    int c[4];
    int v[5];
    int inp, s, ofs;
    ofs = 0;
    inp = num + ((dith && m_lf[0]) ? 1 : 0);
    for (int k = 0; k < 4; k++) begin
      s = m_acc[k] + inp;
      c[k] = (s >= m_den) ? 1 : 0;
      m_acc[k] = (c[k] == 1) ? s - m_den : s;
      inp = m_acc[k];
    end
    for (int k = 0; k < m_ord; k++) begin
      v[0] = c[k];
      for (int j = 1; j <= k; j++) v[j] = m_hist[k][j-1];
      for (int r = 0; r < k; r++)
        for (int j = 0; j < k - r; j++) v[j] = v[j] - v[j+1];
      ofs += v[0];
    end
    for (int k = 0; k < 4; k++) begin
      for (int j = 3; j > 0; j--) m_hist[k][j] = m_hist[k][j-1];
      m_hist[k][0] = c[k];
    end
    m_lf = {m_lf[14:0], m_lf[15] ^ m_lf[13] ^ m_lf[12] ^ m_lf[10]};
    return ofs;
  endfunction

  // R9: reset with a new configuration; output must equal the integer.
  task automatic do_reset(input int o, input int iv, input int n, input int d, input bit dt);
    @(negedge clk);
    srst = 1'b1; ord_v = 2'(o - 1); int_v = INT_W'(iv); num_v = MOD_W'(n);
    den_v = MOD_W'(d); dith_v = dt;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk(int'(div) == iv, "R9 reset output", int'(div), iv);
    srst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      m_acc[k] = 0;
      for (int j = 0; j < 4; j++) m_hist[k][j] = 0;
    end
    m_lf = 16'hACE1; m_ord = o; m_den = d;
  endtask

  // R5 per cycle, with R2/R3/R4 ranges; returns summed offsets.
  task automatic run_cycles(input int n, output longint sum);
    int exp, act;
    sum = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      exp = model_step(int'(num_v), dith_v);
      @(negedge clk);
      act = int'(div) - int'(int_v);
      sum += act;
      chk(act == exp, "R5 sequence", act, exp);
      chk(act >= lo_bound(m_ord) && act <= hi_bound(m_ord),
          (m_ord == 1) ? "R2 range" : (m_ord == 2) ? "R3 range" : "R4 range", act, hi_bound(m_ord));
    end
  endtask

  initial begin
    #(4 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    longint sum;
    int act, got_diff;
    int seq_a [64];
    void'($urandom(32'd20240611));

    // R2: 900 + 1/5 in order one
    do_reset(1, 900, 1, 5, 1'b0);
    for (int i = 1; i <= 15; i++) begin
      @(posedge clk); void'(model_step(1, 1'b0));
      @(negedge clk);
      chk(int'(div) == ((i % 5 == 0) ? 901 : 900), "R2 pattern", int'(div), (i % 5 == 0) ? 901 : 900);
    end

    // R8: zero numerator, all orders
    for (int o = 1; o <= 4; o++) begin
      do_reset(o, 300, 0, 97, 1'b0);
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        chk(int'(div) == 300, "R8 constant", int'(div), 300);
      end
    end

    // R9: order and modulus ignored until reset
    do_reset(1, 900, 1, 5, 1'b0);
    run_cycles(7, sum);
    ord_v = 2'd3; den_v = 16'd3;
    run_cycles(30, sum);
    chk(sum == 6, "R9 config held", int'(sum), 6);
    do_reset(4, 900, 1, 3, 1'b0);
    run_cycles(40, sum);

    // R6 / R7: dither changes the sequence, follows the register model
    do_reset(2, 500, 1, 4, 1'b0);
    for (int i = 0; i < 64; i++) begin
      @(posedge clk); void'(model_step(1, 1'b0));
      @(negedge clk); seq_a[i] = int'(div);
    end
    do_reset(2, 500, 1, 4, 1'b1);
    got_diff = 0;
    for (int i = 0; i < 64; i++) begin
      @(posedge clk); act = model_step(1, 1'b1);
      @(negedge clk);
      chk(int'(div) - 500 == act, "R6 R7 dither sequence", int'(div) - 500, act);
      if (int'(div) != seq_a[i]) got_diff++;
    end
    chk(got_diff > 0, "R6 dither alters pattern", got_diff, 1);

    // R1: long-run average, each order
    for (int o = 1; o <= 4; o++) begin
      do_reset(o, 1000, 333, 1000, 1'b0);
      run_cycles(2000, sum);
      act = int'(sum * 1000 - 2000 * 333);
      if (act < 0) act = -act;
      chk(act <= 8 * 1000, "R1 average", act, 8 * 1000);
    end

    // R4 corner: near-full-scale fraction, largest modulus, dither on
    do_reset(4, 2000, 65534, 65535, 1'b1);
    run_cycles(300, sum);
    do_reset(3, 2000, 65534, 65535, 1'b0);
    run_cycles(300, sum);

    // Random mix: R5 against the model, ranges in every order
    for (int r = 0; r < 24; r++) begin
      int d, n, iv, o;
      d  = int'($urandom_range(65535, 2));
      n  = int'($urandom_range(d - 1, 0));
      iv = int'($urandom_range(4000, 16));
      o  = int'($urandom_range(4, 1));
      do_reset(o, iv, n, d, 1'($urandom_range(1, 0)));
      run_cycles(300, sum);
    end

    finish_run();
  end
endmodule